// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Bank

This block drives the submodules of one converter arm. Each channel holds its own duty reference and compares it with its own carrier. All carriers come from one master counter and differ only by a fixed phase step of one N-th of the period. Each channel drives a complementary pair of gates: an upper gate and a lower gate.

A single shape input sets the carrier waveform for all channels. The sawtooth rises by one count per clock and wraps. The triangle rises and falls by two counts per clock.

A reference is sampled only at fixed points of its own channel's carrier, so a new value never cuts into a comparison that is already under way. A run-time dead-time count holds both gates of a pair low after each change of the switching request.

Top module: `pscpwm_bank`

## Requirements
- R1: While rst_ni is low, and after its release until the first edge, all gates are low when dead_i is nonzero. The master count and all latched references are zero.
- R2: The master count runs 0..PERIOD-1 and then wraps. Channel k has phase p = (count + k*PERIOD/N_SUB) mod PERIOD. With shape_i = 0 (sawtooth) its carrier equals p. Its request is high when the latched reference is greater than the carrier, so with dead_i = 0 and a constant reference r the upper gate is high for min(r, PERIOD) cycles in every period.
- R3: With shape_i = 1 (triangle) the carrier is 2p for p <= PERIOD/2 and 2(PERIOD-p) otherwise. With dead_i = 0 and a constant reference r > 0, the upper gate is high for 1 + 2*min((r-1)/2, PERIOD/2-1) + (r > PERIOD ? 1 : 0) cycles in every period, and never for r = 0.
- R4: The upper gate of channel k+1 turns on PERIOD/N_SUB cycles before that of channel k. The same pattern holds for all other channel pairs.
- R5: The lower gate follows the inverse of the request. The two gates of a pair are never high together, and with dead_i = 0 they are exact complements.
- R6: After the request of a channel changes, both of its gates stay low for dead_i cycles, and then the new gate turns on. A request that lasts fewer than dead_i cycles produces no gate pulse.
- R7: A channel samples its slice of ref_i where p = 0, and also where p = PERIOD/2 in triangle mode. The sampled value is used in the comparison of that same cycle. Changes of ref_i between sample points have no effect on the gates.
- R8: The gates are registered. They show the comparison of a given master count one clock after the edge at which that count is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shape_i | input | 1 | Carrier shape: 0 sawtooth, 1 triangle |
| dead_i | input | DEAD_W | Dead-time in clock cycles |
| ref_i | input | N_SUB*REF_W | Per-channel references; channel k uses bits [k*REF_W +: REF_W] |
| gate_hi_o | output | N_SUB | Upper gate per channel |
| gate_lo_o | output | N_SUB | Lower gate per channel |

## Verification
The reference sample point and a carrier crossing can land in the same cycle. This happens at the sawtooth wrap and the triangle valley or peak, and a new reference must then decide that very comparison. The bench provokes it by changing ref_i at varying offsets around the sample points. It also provokes a second collision, where a request toggles again while the previous dead-time window is still open. For this it runs references close to the carrier extremes with a nonzero dead_i, so that short requests must vanish. Both cases are judged by a cycle-exact arithmetic model of the carriers, sample points and dead-time count, compared with both gate vectors every cycle.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;
  typedef enum logic {
    SHAPE_SAW = 1'b0,
    SHAPE_TRI = 1'b1
  } shape_e;
endpackage

// File: rtl/pscpwm_master_cnt.sv
module pscpwm_master_cnt #(
  parameter int unsigned PERIOD = 16,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/pscpwm_channel.sv
module pscpwm_channel
  import pscpwm_pkg::*;
#(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned N_SUB  = 4,
  parameter int unsigned IDX    = 0,
  localparam int unsigned CNT_W = $clog2(PERIOD),
  localparam int unsigned REF_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] master_i,
  input  shape_e           shape_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             req_o
);
  localparam int unsigned OFFSET = (IDX * PERIOD) / N_SUB;
  localparam logic [REF_W-1:0] PER_V  = REF_W'(PERIOD);
  localparam logic [REF_W-1:0] HALF_V = REF_W'(PERIOD / 2);
  localparam logic [REF_W-1:0] OFF_V  = REF_W'(OFFSET);

  logic [REF_W-1:0] sum, phase, carrier, ref_q, ref_eff;
  logic             latch;

  assign sum   = {1'b0, master_i} + OFF_V;
  assign phase = (sum >= PER_V) ? (sum - PER_V) : sum;

  always_comb begin
    if (shape_i == SHAPE_TRI)
      carrier = (phase <= HALF_V) ? (phase << 1) : ((PER_V - phase) << 1);
    else
      carrier = phase;
  end

  // sample at valley, and at peak for triangle
  assign latch   = (phase == '0) || ((shape_i == SHAPE_TRI) && (phase == HALF_V));
  assign ref_eff = latch ? ref_i : ref_q;
  assign req_o   = ref_eff > carrier;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_q <= '0;
    else if (latch) ref_q <= ref_i;
  end

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i != CNT_W'((PERIOD - OFFSET) % PERIOD)) && (shape_i == SHAPE_SAW)
    |=> $stable(ref_q)); // R7
endmodule

// File: rtl/pscpwm_deadtime.sv
module pscpwm_deadtime #(
  parameter int unsigned DEAD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              hi_o,
  output logic              lo_o
);
  logic              req_q;
  logic [DEAD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (req_i != req_q) begin
      req_q <= req_i;
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hi_o = req_q  && (cnt_q >= dead_i);
  assign lo_o = !req_q && (cnt_q >= dead_i);

  AST_HI_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> $past(req_i) || $past(req_q)); // R5
  AST_LO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> !$past(req_i) || !$past(req_q)); // R5
  AST_DEAD_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hi_o) && (dead_i != '0)) |-> !$past(lo_o)); // R6
  AST_DEAD_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lo_o) && (dead_i != '0)) |-> !$past(hi_o)); // R6
endmodule

// File: rtl/pscpwm_bank.sv
module pscpwm_bank
  import pscpwm_pkg::*;
#(
  parameter int unsigned N_SUB  = 4,
  parameter int unsigned PERIOD = 16,
  parameter int unsigned DEAD_W = 3,
  localparam int unsigned CNT_W = $clog2(PERIOD),
  localparam int unsigned REF_W = CNT_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shape_i,
  input  logic [DEAD_W-1:0]      dead_i,
  input  logic [N_SUB*REF_W-1:0] ref_i,
  output logic [N_SUB-1:0]       gate_hi_o,
  output logic [N_SUB-1:0]       gate_lo_o
);
  logic [CNT_W-1:0] master;
  logic [N_SUB-1:0] req;
  shape_e           shape;

  assign shape = shape_e'(shape_i);

  pscpwm_master_cnt #(.PERIOD(PERIOD)) u_master (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (master)
  );

  for (genvar k = 0; k < N_SUB; k++) begin : g_ch
    pscpwm_channel #(.PERIOD(PERIOD), .N_SUB(N_SUB), .IDX(k)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .master_i(master),
      .shape_i (shape),
      .ref_i   (ref_i[k*REF_W +: REF_W]),
      .req_o   (req[k])
    );

    pscpwm_deadtime #(.DEAD_W(DEAD_W)) u_dt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req[k]),
      .dead_i(dead_i),
      .hi_o  (gate_hi_o[k]),
      .lo_o  (gate_lo_o[k])
    );
  end

  AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == '0); // R5
  AST_ZERO_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i == '0) && $stable(dead_i)) |=> ((gate_hi_o ^ gate_lo_o) == '1)); // R5
endmodule

// File: tb/tb_pscpwm_bank.sv
module tb_pscpwm_bank;
  localparam int N = 4;
  localparam int P = 16;
  localparam int DW = 3;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shape = 1'b0;
  logic [DW-1:0] dead = 3'd2;
  logic [RW-1:0] refv [N];
  logic [N*RW-1:0] ref_bus;
  logic [N-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  int m_cnt;
  int m_ref [N];
  int m_req [N];
  int m_dc  [N];

  always #5 clk = ~clk;

  always_comb for (int k = 0; k < N; k++) ref_bus[k*RW +: RW] = refv[k];

  pscpwm_bank #(.N_SUB(N), .PERIOD(P), .DEAD_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .shape_i(shape), .dead_i(dead),
    .ref_i(ref_bus), .gate_hi_o(hi), .gate_lo_o(lo)
  );

  // cycle model from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int k = 0; k < N; k++) begin m_ref[k] = 0; m_req[k] = 0; m_dc[k] = 0; end
    end else begin
      for (int k = 0; k < N; k++) begin
        int ph, car, eff, r;
        bit lat;
        ph  = (m_cnt + k * P / N) % P;
        car = !shape ? ph : (ph <= P/2 ? 2*ph : 2*(P-ph));
        lat = (ph == 0) || (shape && ph == P/2);
        eff = lat ? int'(refv[k]) : m_ref[k];
        r   = (eff > car) ? 1 : 0;
        if (lat) m_ref[k] = int'(refv[k]);
        if (r != m_req[k]) begin m_req[k] = r; m_dc[k] = 0; end
        else if (m_dc[k] != 7) m_dc[k]++;
      end
      m_cnt = (m_cnt + 1) % P;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_hi();
    int v = 0;
    for (int k = 0; k < N; k++) if (m_req[k] == 1 && m_dc[k] >= int'(dead)) v |= (1 << k);
    return v;
  endfunction

  function automatic int exp_lo();
    int v = 0;
    for (int k = 0; k < N; k++) if (m_req[k] == 0 && m_dc[k] >= int'(dead)) v |= (1 << k);
    return v;
  endfunction

  // R8: registered gates sampled at negedge against model state after the edge
  task automatic step();
    @(negedge clk);
    chk(cur_tag, int'(hi), exp_hi(), "gate_hi (R8 timing)");
    chk(cur_tag, int'(lo), exp_lo(), "gate_lo (R8 timing)");
    chk("R5", int'(hi & lo), 0, "hi&lo overlap");
  endtask

  function automatic int saw_duty(input int r);
    return (r < P) ? r : P;
  endfunction

  function automatic int tri_duty(input int r);
    int e;
    if (r == 0) return 0;
    e = (r - 1) / 2;
    if (e > P/2 - 1) e = P/2 - 1;
    return 1 + 2*e + ((r > P) ? 1 : 0);
  endfunction

  task automatic duty_check(input bit tri_mode);
    int cnt [N];
    for (int k = 0; k < N; k++) cnt[k] = 0;
    for (int c = 0; c < P; c++) begin
      step();
      for (int k = 0; k < N; k++) if (hi[k]) cnt[k]++;
    end
    for (int k = 0; k < N; k++)
      if (tri_mode) chk("R3", cnt[k], tri_duty(int'(refv[k])), "triangle duty");
      else          chk("R2", cnt[k], saw_duty(int'(refv[k])), "sawtooth duty");
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) refv[k] = 5'd9;
    repeat (3) @(negedge clk);
    chk("R1", int'(hi), 0, "hi in reset");
    chk("R1", int'(lo), 0, "lo in reset");
    rst_n = 1'b1;
    chk("R1", int'(hi), 0, "hi after release");
    chk("R1", int'(lo), 0, "lo after release");

    // sweep shapes, dead times and reference sets
    for (int s = 0; s < 2; s++) begin
      for (int di = 0; di < 3; di++) begin
        for (int v = 0; v < 21; v++) begin
          shape = s[0];
          dead = (di == 0) ? 3'd0 : (di == 1) ? 3'd1 : 3'd3;
          cur_tag = (di != 0) ? "R6" : (s == 0) ? "R2" : "R3";
          for (int k = 0; k < N; k++) refv[k] = 5'((v + 5*k) % 21);
          for (int c = 0; c < 2*P; c++) step();
          if (di == 0) duty_check(s[0]);
        end
      end
    end

    // R4: rise offsets between channels
    cur_tag = "R4";
    shape = 1'b0; dead = 3'd0;
    for (int k = 0; k < N; k++) refv[k] = 5'd8;
    for (int c = 0; c < 2*P; c++) step();
    begin
      int rise [N];
      logic [N-1:0] prev;
      prev = hi;
      for (int k = 0; k < N; k++) rise[k] = -1;
      for (int c = 0; c < P; c++) begin
        step();
        for (int k = 0; k < N; k++) if (hi[k] && !prev[k]) rise[k] = c;
        prev = hi;
      end
      for (int k = 0; k + 1 < N; k++)
        chk("R4", (rise[k] - rise[k+1] + P) % P, P / N, "rise offset");
    end

    // R7: reference changes at every offset relative to sample points
    for (int s = 0; s < 2; s++) begin
      shape = s[0]; dead = 3'd1;
      cur_tag = "R7";
      for (int off = 0; off < 40; off++) begin
        for (int k = 0; k < N; k++) refv[k] = 5'((off * 3 + k * 7) % 18);
        for (int c = 0; c < (off % 5) + 1; c++) step();
      end
    end

    // R7: mid-period glitch on ref_i is ignored (sawtooth, channel 0)
    shape = 1'b0; dead = 3'd0;
    for (int k = 0; k < N; k++) refv[k] = 5'd4;
    for (int c = 0; c < 2*P; c++) step();
    while (m_cnt != 6) step();
    refv[0] = 5'd16;
    step();
    refv[0] = 5'd4;
    begin
      int cnt0 = 0;
      for (int c = 0; c < P; c++) begin step(); if (hi[0]) cnt0++; end
      chk("R7", cnt0, 4, "glitch ignored, ch0 duty");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule